// File: doc/BRIEF.md
# NAND chunked page layout remapper

This block sits between the word stream coming out of a NAND flash read path and a page buffer. On the flash device a page is stored as a run of equal chunks. Each chunk holds its data bytes, then 32 spare bytes, then an ECC field. The remapper takes that chunk stream one 64-bit word at a time and writes every word to a byte address in the page buffer. The buffer ends up holding all data bytes of the page in one contiguous region, followed by an out-of-band region.

There are two read modes. In normal mode the ECC words are accepted from the stream but never written, so the out-of-band region holds only the spare bytes of each chunk, in chunk order. In raw mode the out-of-band region holds, for each chunk in order, its spare bytes followed by its ECC bytes. The ECC field length depends on the ECC scheme: BCH always uses 30 bytes, and Hamming uses 6 bytes per 512 data bytes. On the stream the field is padded up to whole words.

The configuration is checked against the 64-bit word size, the 2176-byte on-chip FIFO and the page geometry. It is latched on a start pulse. The control is a three-state machine:
- ST_IDLE: waits for a start pulse. Transition *launch* goes to ST_RUN when the configuration is clean. Transition *reject* stays in ST_IDLE and records the error flags.
- ST_RUN: moves words. Transition *finish* goes to ST_DONE when the last word of the last chunk is accepted.
- ST_DONE: raises the page-done pulse for one cycle. Transition *rearm* returns to ST_IDLE.

Top module: `nand_chunk_remap`

## Requirements
- R1: After reset the block is idle: in_ready_o, wr_valid_o and page_done_o are 0, and cfg_err_o is 3'b000.
- R2: A start_i pulse in idle with a clean configuration latches the configuration and begins a page. cfg_page_sel_i selects the page size: 0 is 2048 bytes, 1 is 4096 bytes, 2 is 8192 bytes. cfg_chunk_bytes_i is the data bytes per chunk. cfg_ecc_ham_i is 0 for BCH and 1 for Hamming. cfg_raw_i is 1 for raw mode. A start_i pulse while a page is in progress has no effect on the addresses or on cfg_err_o.
- R3: Each chunk arrives as 64-bit words in byte-offset order. A chunk is C data bytes, then 32 spare bytes, then E ECC bytes. E is 30 for BCH and 6*(C/512) for Hamming, rounded up to a multiple of 8. Each word that is written carries the input word unchanged on wr_data_o.
- R4: In normal mode, take the word at byte offset o of chunk c (counting from 0), on a page of P bytes. If o < C it is written at address c*C+o. If C <= o < C+32 it is written at address P+c*32+(o-C). ECC words are accepted but never raise wr_valid_o.
- R5: In raw mode, the spare and ECC words at offset o >= C are written at address P+c*(32+E)+(o-C). Data words follow the same rule as in R4.
- R6: While a word is due to be written, in_ready_o follows wr_ready_i, and the address holds across a stall. Dropped ECC words are accepted whatever wr_ready_i is. No word is lost or written twice.
- R7: page_done_o is 1 for exactly the one cycle after the cycle in which the last word of the last chunk is accepted. The block is then idle again and accepts a new start_i.
- R8: cfg_err_o bit 0 is set by a start when C is zero or not a multiple of 8.
- R9: cfg_err_o bit 1 is set by a start when the bytes placed in the 2176-byte FIFO exceed it. In normal mode these are C+32 bytes; in raw mode they are C+32+E bytes.
- R10: cfg_err_o bit 2 is set by a start when any of these holds: cfg_page_sel_i is 3, C is not a power of two, C is below 512, or C is above the page size.
- R11: A start with any error flag set begins no page, and in_ready_o and wr_valid_o stay 0. The flags hold until the next start in idle, and a start with a clean configuration clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-page pulse |
| cfg_page_sel_i | input | 2 | Page size select |
| cfg_chunk_bytes_i | input | 13 | Data bytes per chunk |
| cfg_ecc_ham_i | input | 1 | ECC scheme: 0 BCH, 1 Hamming |
| cfg_raw_i | input | 1 | Raw out-of-band read mode |
| in_valid_i | input | 1 | Stream word valid |
| in_data_i | input | 64 | Stream word |
| in_ready_o | output | 1 | Stream word accepted |
| wr_valid_o | output | 1 | Buffer write request |
| wr_addr_o | output | 14 | Buffer byte address |
| wr_data_o | output | 64 | Buffer write word |
| wr_ready_i | input | 1 | Buffer can take the write |
| page_done_o | output | 1 | One-cycle end-of-page pulse |
| cfg_err_o | output | 3 | Configuration error flags |

## Verification
A wrong chunk offset or base register shows on the very next write, as an address that differs from the formula for that chunk and offset. A slipped boundary between the data, spare and ECC regions shows as an ECC word being written, or a spare word being dropped, within one word of the boundary. A bad last-word decision appears at the end of the page, either as page_done_o one cycle early or late, or as a stream that stops being accepted. A corrupted error latch shows as in_ready_o rising after a rejected start, or as flags that survive a clean one.

// File: rtl/nand_remap_pkg.sv
package nand_remap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } remap_state_t;

    localparam int ERR_ALIGN = 0;
    localparam int ERR_FIFO  = 1;
    localparam int ERR_GEOM  = 2;
    localparam int ERR_W     = 3;
endpackage

// File: rtl/nand_remap_cfg.sv
module nand_remap_cfg
    import nand_remap_pkg::*;
#(
    parameter int LEN_W           = 13,
    parameter int ADDR_W          = 14,
    parameter int ECC_W           = 8,
    parameter int WORD_LOG2       = 3,
    parameter int SPARE_BYTES     = 32,
    parameter int BCH_ECC_BYTES   = 30,
    parameter int HAM_ECC_BYTES   = 6,
    parameter int HAM_SECTOR_LOG2 = 9,
    parameter int FIFO_BYTES      = 2176,
    parameter int MIN_PAGE_LOG2   = 11,
    parameter int MIN_CHUNK_LOG2  = 9
) (
    input  logic [1:0]        page_sel,
    input  logic [LEN_W-1:0]  chunk_bytes,
    input  logic              ecc_ham,
    input  logic              raw_mode,
    output logic [ADDR_W-1:0] page_bytes,
    output logic [ECC_W-1:0]  ecc_pad,
    output logic [ERR_W-1:0]  err
);
    localparam int WORD_BYTES = 1 << WORD_LOG2;
    localparam int SUM_W      = LEN_W + 2;

    logic [ECC_W-1:0] ecc_raw;
    logic [SUM_W-1:0] fifo_bytes;

    always_comb begin
        page_bytes = (page_sel == 2'd3) ? '0
                   : ADDR_W'(1) << (MIN_PAGE_LOG2 + int'(page_sel));
        ecc_raw    = ecc_ham ? ECC_W'(HAM_ECC_BYTES * int'(chunk_bytes >> HAM_SECTOR_LOG2))
                             : ECC_W'(BCH_ECC_BYTES);
        ecc_pad    = (ecc_raw + ECC_W'(WORD_BYTES - 1)) & ~ECC_W'(WORD_BYTES - 1);
        fifo_bytes = SUM_W'(chunk_bytes) + SUM_W'(SPARE_BYTES)
                   + (raw_mode ? SUM_W'(ecc_pad) : SUM_W'(0));

        err[ERR_ALIGN] = (chunk_bytes == '0) || (chunk_bytes[WORD_LOG2-1:0] != '0);
        err[ERR_FIFO]  = fifo_bytes > SUM_W'(FIFO_BYTES);
        err[ERR_GEOM]  = (page_sel == 2'd3)
                      || (chunk_bytes < LEN_W'(1 << MIN_CHUNK_LOG2))
                      || ((chunk_bytes & (chunk_bytes - LEN_W'(1))) != '0)
                      || (ADDR_W'(chunk_bytes) > page_bytes);
    end
endmodule

// File: rtl/nand_remap_addr.sv
module nand_remap_addr #(
    parameter int LEN_W       = 13,
    parameter int ADDR_W      = 14,
    parameter int ECC_W       = 8,
    parameter int WORD_BYTES  = 8,
    parameter int SPARE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] cfg_page,
    input  logic [LEN_W-1:0]  cfg_chunk,
    input  logic [ECC_W-1:0]  cfg_ecc,
    input  logic              cfg_raw,
    output logic [ADDR_W-1:0] addr,
    output logic              drop,
    output logic              last_word
);
    logic [ADDR_W-1:0] page_q, chunk_q, off_q, data_base_q, oob_base_q;
    logic [ECC_W-1:0]  ecc_q;
    logic              raw_q;
    logic [ADDR_W-1:0] total, off_nxt, oob_step;
    logic              chunk_end, in_data;

    always_comb begin
        total     = chunk_q + ADDR_W'(SPARE_BYTES) + ADDR_W'(ecc_q);
        off_nxt   = off_q + ADDR_W'(WORD_BYTES);
        chunk_end = (off_nxt == total);
        last_word = chunk_end && ((data_base_q + chunk_q) == page_q);
        in_data   = off_q < chunk_q;
        drop      = !raw_q && (off_q >= chunk_q + ADDR_W'(SPARE_BYTES));
        oob_step  = ADDR_W'(SPARE_BYTES) + (raw_q ? ADDR_W'(ecc_q) : ADDR_W'(0));
        addr      = in_data ? data_base_q + off_q
                            : page_q + oob_base_q + (off_q - chunk_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q      <= '0;
            chunk_q     <= '0;
            ecc_q       <= '0;
            raw_q       <= 1'b0;
            off_q       <= '0;
            data_base_q <= '0;
            oob_base_q  <= '0;
        end else if (load) begin
            page_q      <= cfg_page;
            chunk_q     <= ADDR_W'(cfg_chunk);
            ecc_q       <= cfg_ecc;
            raw_q       <= cfg_raw;
            off_q       <= '0;
            data_base_q <= '0;
            oob_base_q  <= '0;
        end else if (step) begin
            if (chunk_end) begin
                off_q       <= '0;
                data_base_q <= data_base_q + chunk_q;
                oob_base_q  <= oob_base_q + oob_step;
            end else begin
                off_q <= off_nxt;
            end
        end
    end

    // R4: a word from the data region always lands inside the page data area
    a_r4_data_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (step && in_data) |-> (addr < page_q));

    // R5: out-of-band words always land at or beyond the page data area
    a_r5_oob_above_page: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !in_data) |-> (addr >= page_q));
endmodule

// File: rtl/nand_chunk_remap.sv
module nand_chunk_remap
    import nand_remap_pkg::*;
#(
    parameter int WORD_LOG2   = 3,
    parameter int LEN_W       = 13,
    parameter int ADDR_W      = 14,
    parameter int ECC_W       = 8,
    parameter int SPARE_BYTES = 32,
    parameter int FIFO_BYTES  = 2176
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [1:0]                   cfg_page_sel_i,
    input  logic [LEN_W-1:0]             cfg_chunk_bytes_i,
    input  logic                         cfg_ecc_ham_i,
    input  logic                         cfg_raw_i,
    input  logic                         in_valid_i,
    input  logic [(8<<WORD_LOG2)-1:0]    in_data_i,
    output logic                         in_ready_o,
    output logic                         wr_valid_o,
    output logic [ADDR_W-1:0]            wr_addr_o,
    output logic [(8<<WORD_LOG2)-1:0]    wr_data_o,
    input  logic                         wr_ready_i,
    output logic                         page_done_o,
    output logic [ERR_W-1:0]             cfg_err_o
);
    localparam int WORD_BYTES = 1 << WORD_LOG2;

    remap_state_t      state_q, state_d;
    logic [ADDR_W-1:0] page_bytes;
    logic [ECC_W-1:0]  ecc_pad;
    logic [ERR_W-1:0]  cfg_err_d, cfg_err_q;
    logic              go, load, accept, drop, last_word, run;

    nand_remap_cfg #(
        .LEN_W(LEN_W), .ADDR_W(ADDR_W), .ECC_W(ECC_W), .WORD_LOG2(WORD_LOG2),
        .SPARE_BYTES(SPARE_BYTES), .FIFO_BYTES(FIFO_BYTES)
    ) cfg_i (
        .page_sel(cfg_page_sel_i), .chunk_bytes(cfg_chunk_bytes_i),
        .ecc_ham(cfg_ecc_ham_i), .raw_mode(cfg_raw_i),
        .page_bytes(page_bytes), .ecc_pad(ecc_pad), .err(cfg_err_d)
    );

    nand_remap_addr #(
        .LEN_W(LEN_W), .ADDR_W(ADDR_W), .ECC_W(ECC_W),
        .WORD_BYTES(WORD_BYTES), .SPARE_BYTES(SPARE_BYTES)
    ) addr_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(accept),
        .cfg_page(page_bytes), .cfg_chunk(cfg_chunk_bytes_i),
        .cfg_ecc(ecc_pad), .cfg_raw(cfg_raw_i),
        .addr(wr_addr_o), .drop(drop), .last_word(last_word)
    );

    assign go     = start_i && (cfg_err_d == '0);
    assign load   = (state_q == ST_IDLE) && go;
    assign accept = in_valid_i && in_ready_o;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_RUN;
            ST_RUN:  if (accept && last_word) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cfg_err_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) cfg_err_q <= cfg_err_d;
        end
    end

    always_comb begin
        run         = (state_q == ST_RUN);
        in_ready_o  = run && (drop || wr_ready_i);
        wr_valid_o  = run && in_valid_i && !drop;
        wr_data_o   = in_data_i;
        page_done_o = (state_q == ST_DONE);
        cfg_err_o   = cfg_err_q;
    end

    // R7: the end-of-page pulse lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        page_done_o |=> !page_done_o);

    // R6: a stalled write keeps its address until it is taken
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> $stable(wr_addr_o));

    // R11: latched error flags never coexist with a running page
    a_r11_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o != '0) |-> !run);

    // R1: outside a page nothing is accepted from the stream
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (!in_ready_o && !wr_valid_o));
endmodule

// File: tb/nand_chunk_remap_tb_top.sv
module nand_chunk_remap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  cfg_page_sel_i = '0;
    logic [12:0] cfg_chunk_bytes_i = '0;
    logic        cfg_ecc_ham_i = 1'b0;
    logic        cfg_raw_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [63:0] in_data_i = '0;
    logic        in_ready_o, wr_valid_o, page_done_o;
    logic [13:0] wr_addr_o;
    logic [63:0] wr_data_o;
    logic        wr_ready_i = 1'b1;
    logic [2:0]  cfg_err_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit stall_en = 1'b0;
    string cur_tag = "R4";
    logic [13:0] exp_addr_q[$];
    logic [63:0] exp_data_q[$];

    always #5 clk = ~clk;

    nand_chunk_remap dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_page_sel_i(cfg_page_sel_i), .cfg_chunk_bytes_i(cfg_chunk_bytes_i),
        .cfg_ecc_ham_i(cfg_ecc_ham_i), .cfg_raw_i(cfg_raw_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_ready_i(wr_ready_i), .page_done_o(page_done_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // R6 stall pattern on the buffer side
    always @(posedge clk) begin
        cyc++;
        #1 wr_ready_i = stall_en ? ((cyc % 3) != 0) : 1'b1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_valid_o && wr_ready_i) begin
            if (exp_addr_q.size() == 0) begin
                chk(cur_tag, "unexpected write addr", 64'(wr_addr_o), 64'h3fff_ffff);
            end else begin
                chk(cur_tag, "write addr", 64'(wr_addr_o), 64'(exp_addr_q.pop_front()));
                chk("R3", "write data", wr_data_o, exp_data_q.pop_front());
            end
        end
    end

    task automatic pulse_start();
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic send_word(input logic [63:0] d);
        in_valid_i = 1'b1;
        in_data_i  = d;
        forever begin
            @(negedge clk);
            if (in_ready_o) break;
        end
        @(posedge clk); #1;
        in_valid_i = 1'b0;
    endtask

    task automatic run_page(input int pid, input logic [1:0] psel, input int chunk,
                            input bit ham, input bit raw, input bit stall,
                            input string tag, input bit poke_start);
        int p, e, step, total, nch;
        p = 2048 << psel;
        e = ham ? 6 * (chunk / 512) : 30;
        e = (e + 7) / 8 * 8;
        step = 32 + (raw ? e : 0);
        total = chunk + 32 + e;
        nch = p / chunk;
        cur_tag = tag;
        stall_en = stall;
        cfg_page_sel_i = psel; cfg_chunk_bytes_i = 13'(chunk);
        cfg_ecc_ham_i = ham; cfg_raw_i = raw;
        pulse_start();
        @(negedge clk);
        chk("R11", "cfg_err after clean start", 64'(cfg_err_o), 64'd0);
        @(posedge clk); #1;
        for (int c = 0; c < nch; c++) begin
            if (poke_start && c == 1) begin
                // R2: a start during the page must be ignored
                cfg_page_sel_i = 2'd3; cfg_chunk_bytes_i = 13'd100;
                pulse_start();
                @(negedge clk);
                chk("R2", "cfg_err after start mid-page", 64'(cfg_err_o), 64'd0);
                @(posedge clk); #1;
                cfg_page_sel_i = psel; cfg_chunk_bytes_i = 13'(chunk);
            end
            for (int o = 0; o < total; o += 8) begin
                logic [63:0] d;
                d = {16'(pid), 16'(c), 16'(o), 16'hC35A};
                if (o < chunk) begin
                    exp_addr_q.push_back(14'(c * chunk + o));
                    exp_data_q.push_back(d);
                end else if (raw || o < chunk + 32) begin
                    exp_addr_q.push_back(14'(p + c * step + (o - chunk)));
                    exp_data_q.push_back(d);
                end
                send_word(d);
            end
        end
        @(negedge clk);
        chk("R7", "page_done after last word", 64'(page_done_o), 64'd1);
        @(negedge clk);
        chk("R7", "page_done one cycle later", 64'(page_done_o), 64'd0);
        chk("R6", "words left unwritten", 64'(exp_addr_q.size()), 64'd0);
        stall_en = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic bad_cfg(input logic [1:0] psel, input int chunk, input bit ham,
                           input bit raw, input logic [2:0] exp_err, input string tag);
        cfg_page_sel_i = psel; cfg_chunk_bytes_i = 13'(chunk);
        cfg_ecc_ham_i = ham; cfg_raw_i = raw;
        pulse_start();
        @(negedge clk);
        chk(tag, "cfg_err flags", 64'(cfg_err_o), 64'(exp_err));
        @(posedge clk); #1;
        in_valid_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11", "in_ready after rejected start", 64'(in_ready_o), 64'd0);
            chk("R11", "wr_valid after rejected start", 64'(wr_valid_o), 64'd0);
        end
        @(posedge clk); #1;
        in_valid_i = 1'b0;
        chk("R11", "flags held", 64'(cfg_err_o), 64'(exp_err));
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual timeout expected page completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "in_ready after reset", 64'(in_ready_o), 64'd0);
        chk("R1", "wr_valid after reset", 64'(wr_valid_o), 64'd0);
        chk("R1", "page_done after reset", 64'(page_done_o), 64'd0);
        chk("R1", "cfg_err after reset", 64'(cfg_err_o), 64'd0);
        @(posedge clk); #1;

        run_page(1, 2'd1, 2048, 1'b0, 1'b0, 1'b0, "R4", 1'b1);
        run_page(2, 2'd0, 2048, 1'b1, 1'b1, 1'b0, "R5", 1'b0);
        run_page(3, 2'd2, 1024, 1'b0, 1'b1, 1'b1, "R5", 1'b0);
        run_page(4, 2'd1, 512,  1'b1, 1'b0, 1'b1, "R6", 1'b0);

        bad_cfg(2'd1, 1020, 1'b0, 1'b0, 3'b101, "R8");
        bad_cfg(2'd2, 4096, 1'b0, 1'b0, 3'b010, "R9");
        bad_cfg(2'd0, 4096, 1'b1, 1'b1, 3'b110, "R9");
        bad_cfg(2'd3, 2048, 1'b0, 1'b0, 3'b100, "R10");
        bad_cfg(2'd0, 256,  1'b0, 1'b0, 3'b100, "R10");

        // R11: a clean start after a rejected one clears the flags and runs
        run_page(5, 2'd0, 1024, 1'b1, 1'b0, 1'b0, "R4", 1'b0);
        finish_run();
    end
endmodule